// File: doc/BRIEF.md
# HDLC Receive Block FIFO with Event Queue

This block sits between an HDLC deframer and a host processor. It stores received frame bytes in a circular buffer of two equal blocks (64 bytes with the default 32-byte block). The host drains the buffer one segment at a time. Every segment is announced by an event: a block-full event when a frame that is still running has filled a block, or an end event when a frame closes. After the last data byte of every frame the block writes one status byte, so the closing segment holds the frame's tail followed by that byte.

Events wait in a small queue, and the host sees only the event at the head. The host pulls bytes of the current segment through a read strobe. A release strobe frees the segment and retires its event, and the next event appears on the following cycle. A discard strobe throws away the unreported part of the frame being received and drops the rest of it. When the buffer or the queue has too little room, bytes, whole frames or block-full events are dropped according to fixed rules, and flags report each case.

Top module: `hdlc_rx_blockfifo`

## Requirements
- R1: After reset, ev_valid, frame_lost and evq_overflow are 0.
- R2: When a frame closes with rx_close high, a status byte is appended with bit0 = abort, bit1 = CRC error, bit2 = data overflow and bits 7..3 = 0. An end event (ev_kind = 1) is queued with ev_flen = number of data bytes stored for the frame and ev_seg = data bytes since the last block-full event plus 1.
- R3: When a stored data byte brings the open segment of a running frame to BLK bytes and the queue holds at most QDEPTH-2 events, a block-full event (ev_kind = 0) is queued with ev_seg = BLK and ev_flen = bytes stored so far, and a new segment begins.
- R4: A frame longer than BLK yields one block-full event per full block and then an end event covering only the remainder plus the status byte.
- R5: A data byte is stored only when at least two of the 2*BLK buffer entries are free (counted before any release in the same cycle). Otherwise the byte is dropped and the frame's data-overflow bit is set.
- R6: A first-marked byte that arrives with no frame open, while fewer than two buffer entries are free or the queue holds QDEPTH events, pulses frame_lost for one cycle. That frame is then ignored up to and including its rx_close and queues no event.
- R7: Queued events are shown one at a time in arrival order. host_release with ev_valid high frees ev_seg buffer entries and retires the event, and the next event is shown on the next cycle.
- R8: rd_data shows the byte at the read position, which starts at the first byte of the current segment. host_rd moves it forward by one only while it is short of ev_seg, and host_release moves it to the start of the next segment.
- R9: host_discard while a frame is open removes the bytes of its open segment from the buffer. The remaining bytes up to rx_close are dropped, and neither a status byte nor an end event is produced.
- R10: If a block-full event is due while the queue holds more than QDEPTH-2 events, no event is queued, the segment stays open and keeps growing, and evq_overflow is set and stays set until reset.
- R11: On a cycle with rx_close high, rx_valid is ignored. Bytes without rx_first outside a frame and rx_close outside a frame are ignored. rx_first on a byte inside an open frame is treated as an ordinary data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A data byte is present on rx_data |
| rx_data | input | 8 | Received data byte |
| rx_first | input | 1 | Byte is the first of a frame |
| rx_close | input | 1 | Frame closing marker (no data byte) |
| rx_abort | input | 1 | Closing frame was aborted (with rx_close) |
| rx_crc_bad | input | 1 | Closing frame failed its CRC (with rx_close) |
| host_rd | input | 1 | Advance the read position by one byte |
| host_release | input | 1 | Free the current segment and retire its event |
| host_discard | input | 1 | Drop the frame now being received |
| rd_data | output | 8 | Byte at the read position |
| ev_valid | output | 1 | An event is shown |
| ev_kind | output | 1 | 0 = block full, 1 = frame end |
| ev_seg | output | 7 | Bytes in the current segment |
| ev_flen | output | 12 | Frame length so far (final length on an end event) |
| frame_lost | output | 1 | One-cycle pulse: a frame start was refused |
| evq_overflow | output | 1 | Sticky: a block-full event could not be queued |

## Verification
The hardest state to reach is a block-full event that falls due while the event queue is nearly full. The queue fills only when many frames stay unreleased, yet the buffer must still have room. The stimulus sends fifteen one-byte frames without releasing any, which leaves fifteen events but only thirty bytes in use. A 33-byte frame then crosses the block boundary with one queue slot left, and its block-full event is merged into a 34-byte end segment. Buffer overflow and refused frame starts are reached in the same way: a long frame is sent with no release, and a new frame is started on the full buffer.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RECV = 2'd1,
        WS_SKIP = 2'd2
    } wstate_e;

    localparam logic EV_POOL = 1'b0;
    localparam logic EV_END  = 1'b1;

    localparam int ST_ABORT = 0;
    localparam int ST_CRC   = 1;
    localparam int ST_OVF   = 2;
endpackage

// File: rtl/hdlc_rx_store.sv
module hdlc_rx_store #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/hdlc_rx_evq.sv
module hdlc_rx_evq #(
    parameter int QDEPTH = 16,
    parameter int CW     = 7,
    parameter int LEN_W  = 12,
    parameter int QCW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_kind,
    input  logic [CW-1:0]    push_seg,
    input  logic [LEN_W-1:0] push_flen,
    input  logic             pop,
    output logic             head_valid,
    output logic             head_kind,
    output logic [CW-1:0]    head_seg,
    output logic [LEN_W-1:0] head_flen,
    output logic [QCW-1:0]   count
);
    localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam logic [QCW-1:0] Q_FULL = QCW'(QDEPTH);
    localparam logic [QAW-1:0] Q_LAST = QAW'(QDEPTH - 1);

    typedef struct packed {
        logic [QAW-1:0] rd;
        logic [QAW-1:0] wr;
        logic [QCW-1:0] cnt;
    } qptr_s;

    qptr_s p_q, p_d;
    logic do_push, do_pop;

    logic             kind_m [QDEPTH];
    logic [CW-1:0]    seg_m  [QDEPTH];
    logic [LEN_W-1:0] flen_m [QDEPTH];

    function automatic logic [QAW-1:0] step(input logic [QAW-1:0] p);
        return (p == Q_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        p_d     = p_q;
        do_push = push && (p_q.cnt < Q_FULL);
        do_pop  = pop && (p_q.cnt != '0);
        if (do_push) begin
            p_d.wr = step(p_q.wr);
        end
        if (do_pop) begin
            p_d.rd = step(p_q.rd);
        end
        if (do_push && !do_pop) begin
            p_d.cnt = p_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            p_d.cnt = p_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    generate
        for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (do_push && (p_q.wr == QAW'(i))) begin
                    kind_m[i] <= push_kind;
                    seg_m[i]  <= push_seg;
                    flen_m[i] <= push_flen;
                end
            end
        end
    endgenerate

    assign head_valid = (p_q.cnt != '0);
    assign head_kind  = kind_m[p_q.rd];
    assign head_seg   = seg_m[p_q.rd];
    assign head_flen  = flen_m[p_q.rd];
    assign count      = p_q.cnt;

    p_push_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < Q_FULL));
    p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/hdlc_rx_wrctl.sv
module hdlc_rx_wrctl
    import hdlc_rx_pkg::*;
#(
    parameter int BLK    = 32,
    parameter int DEPTH  = 64,
    parameter int QDEPTH = 16,
    parameter int AW     = 6,
    parameter int CW     = 7,
    parameter int QCW    = 5,
    parameter int LEN_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_first,
    input  logic             rx_close,
    input  logic             rx_abort,
    input  logic             rx_crc_bad,
    input  logic             host_discard,
    input  logic [CW-1:0]    freed,
    input  logic [QCW-1:0]   q_count,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [7:0]       wdata,
    output logic             push,
    output logic             push_kind,
    output logic [CW-1:0]    push_seg,
    output logic [LEN_W-1:0] push_flen,
    output logic             frame_lost,
    output logic             qovf
);
    localparam logic [CW-1:0]  BUF_SIZE = CW'(DEPTH);
    localparam logic [CW-1:0]  BLK_SIZE = CW'(BLK);
    localparam logic [CW-1:0]  ROOM_MIN = CW'(2);
    localparam logic [QCW-1:0] Q_FULL   = QCW'(QDEPTH);
    localparam logic [QCW-1:0] Q_LIM2   = QCW'(QDEPTH - 2);

    typedef struct packed {
        wstate_e          st;
        logic [AW-1:0]    wp;
        logic [CW-1:0]    used;
        logic [CW-1:0]    seg;
        logic [LEN_W-1:0] flen;
        logic             ovf;
        logic             qovf;
        logic             lost;
    } wr_s;

    wr_s s_q, s_d;
    logic [CW-1:0]    room;
    logic [CW-1:0]    seg_inc;
    logic [LEN_W-1:0] flen_inc;

    always_comb begin
        s_d       = s_q;
        s_d.lost  = 1'b0;
        we        = 1'b0;
        waddr     = s_q.wp;
        wdata     = rx_data;
        push      = 1'b0;
        push_kind = EV_POOL;
        room      = BUF_SIZE - s_q.used;
        seg_inc   = s_q.seg + 1'b1;
        flen_inc  = s_q.flen + 1'b1;
        push_seg  = seg_inc;
        push_flen = s_q.flen;

        case (s_q.st)
            WS_IDLE: begin
                if (rx_valid && !rx_close && rx_first) begin
                    if ((room >= ROOM_MIN) && (q_count < Q_FULL)) begin
                        we       = 1'b1;
                        s_d.wp   = s_q.wp + 1'b1;
                        s_d.used = s_q.used + 1'b1;
                        s_d.seg  = CW'(1);
                        s_d.flen = LEN_W'(1);
                        s_d.ovf  = 1'b0;
                        s_d.st   = WS_RECV;
                    end else begin
                        s_d.lost = 1'b1;
                        s_d.st   = WS_SKIP;
                    end
                end
            end
            WS_RECV: begin
                if (host_discard) begin
                    s_d.wp   = s_q.wp - AW'(s_q.seg);
                    s_d.used = s_q.used - s_q.seg;
                    s_d.seg  = '0;
                    s_d.st   = rx_close ? WS_IDLE : WS_SKIP;
                end else if (rx_close) begin
                    we              = 1'b1;
                    wdata           = '0;
                    wdata[ST_ABORT] = rx_abort;
                    wdata[ST_CRC]   = rx_crc_bad;
                    wdata[ST_OVF]   = s_q.ovf;
                    s_d.wp          = s_q.wp + 1'b1;
                    s_d.used        = s_q.used + 1'b1;
                    s_d.seg         = '0;
                    push            = 1'b1;
                    push_kind       = EV_END;
                    s_d.st          = WS_IDLE;
                end else if (rx_valid) begin
                    if (room >= ROOM_MIN) begin
                        we       = 1'b1;
                        s_d.wp   = s_q.wp + 1'b1;
                        s_d.used = s_q.used + 1'b1;
                        s_d.seg  = seg_inc;
                        s_d.flen = flen_inc;
                        if (seg_inc >= BLK_SIZE) begin
                            if (q_count <= Q_LIM2) begin
                                push      = 1'b1;
                                push_kind = EV_POOL;
                                push_flen = flen_inc;
                                s_d.seg   = '0;
                            end else begin
                                s_d.qovf = 1'b1;
                            end
                        end
                    end else begin
                        s_d.ovf = 1'b1;
                    end
                end
            end
            WS_SKIP: begin
                if (rx_close) begin
                    s_d.st = WS_IDLE;
                end
            end
            default: s_d.st = WS_IDLE;
        endcase

        s_d.used = s_d.used - freed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= WS_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_lost = s_q.lost;
    assign qovf       = s_q.qovf;

    p_used_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.used <= BUF_SIZE);
    p_close_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == WS_RECV && rx_close && !host_discard) |-> (s_q.used < BUF_SIZE));
    p_lost_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lost |=> !frame_lost);
    p_qovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        qovf |=> qovf);
endmodule

// File: rtl/hdlc_rx_blockfifo.sv
module hdlc_rx_blockfifo #(
    parameter int BLK    = 32,
    parameter int QDEPTH = 16,
    parameter int LEN_W  = 12,
    localparam int DEPTH = 2 * BLK,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int QCW   = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_first,
    input  logic             rx_close,
    input  logic             rx_abort,
    input  logic             rx_crc_bad,
    input  logic             host_rd,
    input  logic             host_release,
    input  logic             host_discard,
    output logic [7:0]       rd_data,
    output logic             ev_valid,
    output logic             ev_kind,
    output logic [CW-1:0]    ev_seg,
    output logic [LEN_W-1:0] ev_flen,
    output logic             frame_lost,
    output logic             evq_overflow
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] off;
    } host_s;

    host_s h_q, h_d;
    logic             pop;
    logic [CW-1:0]    freed;
    logic [AW-1:0]    raddr;
    logic             we;
    logic [AW-1:0]    waddr;
    logic [7:0]       wdata;
    logic             push;
    logic             push_kind;
    logic [CW-1:0]    push_seg;
    logic [LEN_W-1:0] push_flen;
    logic [QCW-1:0]   q_count;

    always_comb begin
        h_d   = h_q;
        pop   = 1'b0;
        freed = '0;
        if (host_release && ev_valid) begin
            pop      = 1'b1;
            freed    = ev_seg;
            h_d.base = h_q.base + AW'(ev_seg);
            h_d.off  = '0;
        end else if (host_rd && ev_valid && (h_q.off < ev_seg)) begin
            h_d.off = h_q.off + 1'b1;
        end
        raddr = h_q.base + AW'(h_q.off);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    hdlc_rx_wrctl #(
        .BLK(BLK), .DEPTH(DEPTH), .QDEPTH(QDEPTH),
        .AW(AW), .CW(CW), .QCW(QCW), .LEN_W(LEN_W)
    ) u_wrctl (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
        .rx_close(rx_close), .rx_abort(rx_abort), .rx_crc_bad(rx_crc_bad),
        .host_discard(host_discard), .freed(freed), .q_count(q_count),
        .we(we), .waddr(waddr), .wdata(wdata),
        .push(push), .push_kind(push_kind), .push_seg(push_seg), .push_flen(push_flen),
        .frame_lost(frame_lost), .qovf(evq_overflow)
    );

    hdlc_rx_evq #(
        .QDEPTH(QDEPTH), .CW(CW), .LEN_W(LEN_W), .QCW(QCW)
    ) u_evq (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_kind(push_kind), .push_seg(push_seg), .push_flen(push_flen),
        .pop(pop),
        .head_valid(ev_valid), .head_kind(ev_kind), .head_seg(ev_seg), .head_flen(ev_flen),
        .count(q_count)
    );

    hdlc_rx_store #(
        .DEPTH(DEPTH), .AW(AW)
    ) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rd_data)
    );

    p_off_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (h_q.off <= ev_seg));
    p_seg_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_seg != '0));
endmodule

// File: tb/hdlc_rx_blockfifo_tb.sv
`timescale 1ns/1ps
module hdlc_rx_blockfifo_tb;
    localparam int BLK = 32;
    localparam int QD  = 16;
    localparam int DEP = 2 * BLK;

    logic clk = 1'b0;
    logic rst_n;
    logic rx_valid, rx_first, rx_close, rx_abort, rx_crc_bad;
    logic [7:0] rx_data;
    logic host_rd, host_release, host_discard;
    logic [7:0] rd_data;
    logic ev_valid, ev_kind, frame_lost, evq_overflow;
    logic [6:0] ev_seg;
    logic [11:0] ev_flen;

    always #2 clk = ~clk;

    hdlc_rx_blockfifo #(.BLK(BLK), .QDEPTH(QD), .LEN_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
        .rx_close(rx_close), .rx_abort(rx_abort), .rx_crc_bad(rx_crc_bad),
        .host_rd(host_rd), .host_release(host_release), .host_discard(host_discard),
        .rd_data(rd_data), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_seg(ev_seg), .ev_flen(ev_flen),
        .frame_lost(frame_lost), .evq_overflow(evq_overflow)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_mem [DEP];
    int m_used, m_wp, m_st, m_seg, m_flen, m_ovf, m_qovf, m_lost, m_base, m_off;
    int m_ek[$];
    int m_es[$];
    int m_ef[$];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset;
        m_used = 0; m_wp = 0; m_st = 0; m_seg = 0; m_flen = 0;
        m_ovf = 0; m_qovf = 0; m_lost = 0; m_base = 0; m_off = 0;
        m_ek.delete(); m_es.delete(); m_ef.delete();
    endtask

    task automatic mstore(input int v);
        m_mem[m_wp] = v;
        m_wp = (m_wp + 1) % DEP;
        m_used++;
    endtask

    task automatic model_step;
        int qc, fr, freed;
        qc = m_ek.size();
        fr = DEP - m_used;
        freed = 0;
        if (host_release && qc > 0) begin
            freed = m_es[0];
            m_base = (m_base + freed) % DEP;
            m_off = 0;
            void'(m_ek.pop_front()); void'(m_es.pop_front()); void'(m_ef.pop_front());
        end else if (host_rd && qc > 0 && m_off < m_es[0]) begin
            m_off++;
        end
        m_lost = 0;
        case (m_st)
            0: if (rx_valid && !rx_close && rx_first) begin
                if (fr >= 2 && qc < QD) begin
                    mstore(rx_data); m_seg = 1; m_flen = 1; m_ovf = 0; m_st = 1;
                end else begin
                    m_lost = 1; m_st = 2;
                end
            end
            1: if (host_discard) begin
                m_wp = (m_wp - m_seg + DEP) % DEP;
                m_used -= m_seg; m_seg = 0;
                m_st = rx_close ? 0 : 2;
            end else if (rx_close) begin
                mstore(m_ovf * 4 + rx_crc_bad * 2 + rx_abort);
                m_ek.push_back(1); m_es.push_back(m_seg + 1); m_ef.push_back(m_flen);
                m_seg = 0; m_st = 0;
            end else if (rx_valid) begin
                if (fr >= 2) begin
                    mstore(rx_data); m_seg++; m_flen++;
                    if (m_seg >= BLK) begin
                        if (qc <= QD - 2) begin
                            m_ek.push_back(0); m_es.push_back(m_seg); m_ef.push_back(m_flen);
                            m_seg = 0;
                        end else m_qovf = 1;
                    end
                end else m_ovf = 1;
            end
            default: if (rx_close) m_st = 0;
        endcase
        m_used -= freed;
    endtask

    task automatic cmp_all;
        chk("R7 ev_valid", ev_valid, m_ek.size() > 0);
        chk("R6 frame_lost", frame_lost, m_lost);
        chk("R10 evq_overflow", evq_overflow, m_qovf);
        if (m_ek.size() > 0) begin
            chk("R3 ev_kind", ev_kind, m_ek[0]);
            chk("R4 ev_seg", ev_seg, m_es[0]);
            chk("R2 ev_flen", ev_flen, m_ef[0]);
            if (m_off < m_es[0])
                chk("R8 rd_data", rd_data, m_mem[(m_base + m_off) % DEP]);
        end
    endtask

    task automatic clear_in;
        rx_valid = 0; rx_first = 0; rx_close = 0; rx_abort = 0; rx_crc_bad = 0;
        rx_data = 8'h00; host_rd = 0; host_release = 0; host_discard = 0;
    endtask

    task automatic tick;
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        if (rst_n) cmp_all();
        clear_in();
    endtask

    task automatic send_byte(input bit first, input int v);
        rx_valid = 1; rx_first = first; rx_data = 8'(v);
        tick();
    endtask

    task automatic close_frame(input bit ab, input bit crc);
        rx_close = 1; rx_abort = ab; rx_crc_bad = crc;
        tick();
    endtask

    task automatic send_frame(input int n, input int v0);
        for (int i = 0; i < n; i++) send_byte(i == 0, v0 + i);
        close_frame(0, 0);
    endtask

    task automatic read_all;
        int n;
        n = (m_ek.size() > 0) ? m_es[0] - m_off : 0;
        for (int i = 0; i < n; i++) begin
            host_rd = 1;
            tick();
        end
    endtask

    task automatic release_blk;
        host_release = 1;
        tick();
    endtask

    task automatic drain;
        while (m_ek.size() != 0) begin
            read_all();
            release_blk();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 ev_valid after reset", ev_valid, 0);
        chk("R1 frame_lost after reset", frame_lost, 0);
        chk("R1 evq_overflow after reset", evq_overflow, 0);
        tick();

        // short frame with CRC error
        for (int i = 0; i < 5; i++) send_byte(i == 0, 8'h10 + i);
        close_frame(0, 1);
        chk("R2 end kind", ev_kind, 1);
        chk("R2 end seg", ev_seg, 6);
        chk("R2 end flen", ev_flen, 5);
        chk("R8 first byte", rd_data, 8'h10);
        for (int i = 0; i < 5; i++) begin host_rd = 1; tick(); end
        chk("R2 status byte crc", rd_data, 8'h02);
        host_rd = 1; tick();
        host_rd = 1; tick();
        release_blk();
        chk("R7 queue empty", ev_valid, 0);

        // several short frames queued
        send_frame(3, 8'h20);
        send_frame(4, 8'h30);
        send_frame(2, 8'h38);
        release_blk();
        chk("R7 next event flen", ev_flen, 4);
        release_blk();
        chk("R7 third event flen", ev_flen, 2);
        read_all();
        release_blk();

        // long frame with prompt releases
        for (int i = 0; i < 32; i++) send_byte(i == 0, 8'h40 + i);
        chk("R3 pool kind", ev_kind, 0);
        chk("R3 pool seg", ev_seg, 32);
        read_all(); release_blk();
        for (int i = 32; i < 64; i++) send_byte(0, 8'h40 + i);
        read_all(); release_blk();
        for (int i = 64; i < 70; i++) send_byte(0, 8'h40 + i);
        close_frame(0, 0);
        chk("R4 end seg", ev_seg, 7);
        chk("R4 end flen", ev_flen, 70);
        read_all(); release_blk();

        // long frame without release: data overflow, then refused frame
        for (int i = 0; i < 70; i++) send_byte(i == 0, 8'h80 + i);
        close_frame(0, 0);
        send_byte(1, 8'h55);
        chk("R6 lost pulse", frame_lost, 1);
        send_byte(0, 8'h56);
        close_frame(0, 0);
        chk("R6 head unchanged", ev_seg, 32);
        read_all(); release_blk();
        chk("R5 end seg", ev_seg, 32);
        chk("R5 end flen", ev_flen, 63);
        for (int i = 0; i < 31; i++) begin host_rd = 1; tick(); end
        chk("R5 overflow status", rd_data, 8'h04);
        release_blk();

        // discard
        for (int i = 0; i < 10; i++) send_byte(i == 0, 8'h90 + i);
        host_discard = 1; tick();
        for (int i = 0; i < 3; i++) send_byte(0, 8'hA0 + i);
        close_frame(0, 0);
        chk("R9 no event after discard", ev_valid, 0);
        send_frame(2, 8'hC0);
        chk("R9 next frame seg", ev_seg, 3);
        chk("R9 next frame data", rd_data, 8'hC0);
        drain();

        // queue nearly full: merged block event
        for (int f = 0; f < 15; f++) send_frame(1, f);
        for (int i = 0; i < 33; i++) send_byte(i == 0, 8'hD0 + i);
        chk("R10 sticky set", evq_overflow, 1);
        close_frame(0, 0);
        drain();
        chk("R10 still set", evq_overflow, 1);

        // input corner cases
        send_byte(0, 8'h11);
        tick();
        chk("R11 stray byte ignored", ev_valid, 0);
        close_frame(0, 0);
        send_byte(1, 8'hE0);
        send_byte(1, 8'hE1);
        send_byte(0, 8'hE2);
        rx_valid = 1; rx_data = 8'hEE;
        close_frame(1, 0);
        chk("R11 flen", ev_flen, 3);
        chk("R11 seg", ev_seg, 4);
        for (int i = 0; i < 3; i++) begin host_rd = 1; tick(); end
        chk("R11 abort status", rd_data, 8'h01);
        drain();
        repeat (3) tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule